// File: doc/BRIEF.md
# Byte-Wide UV-Erasable Memory with Mode Control

This block models a byte-wide, ultraviolet-erasable read-only memory as it appears to the logic around it. Four control inputs pick the operating mode together: an active-low select that doubles as the program strobe, an active-low read enable, a flag that says the programming supply is raised, and a flag that asks for the identification code. The memory can be read, kept off the bus, parked in standby, programmed one byte at a time, read back for verification with the programming supply raised, protected from a strobe aimed at another device, and asked for its maker and device codes.

The data output is split into a value and a drive-enable so that a chip-level wrapper can build the tri-state pad. Programming can only clear bits: each completed program strobe merges the presented byte into the stored one with a bitwise AND. A separate erase request stands in for the ultraviolet lamp; it sweeps the array one byte per cycle, setting every byte to all ones, and holds a busy flag while it runs. The array size is a parameter; `ADDR_W` of 15 gives the full 32K x 8 array, while the default keeps elaboration small.

Top module: `uvprom_core`

## Requirements
- R1: One cycle after `erase_req` is sampled high while idle, `erase_busy` rises and stays high for exactly 2**ADDR_W cycles; afterwards every byte reads 0xFF.
- R2: A completed program strobe stores the old byte AND the presented byte, so a bit already at 0 stays 0 even when a 1 is presented.
- R3: With `sel_n`=0, `rd_en_n`=0, `hv_on`=0 and `sig_on`=0, the outputs of the next cycle are `dout_oe`=1 and `dout` equal to the byte at `addr`.
- R4: With `hv_on`=0 and `sel_n`=1 (standby), the next cycle has `dout_oe`=0 whatever `rd_en_n` is.
- R5: With `rd_en_n`=1, the next cycle has `dout_oe`=0 even when `sel_n`=0 (output disable).
- R6: With `hv_on`=1, `rd_en_n`=1 and `sel_n`=0 the block takes `din` and does not drive; exactly one write, of the `addr`/`din` sampled in the last strobe cycle, happens in the cycle `sel_n` returns high with `hv_on` and `rd_en_n` still high. A strobe that ends any other way writes nothing.
- R7: With `hv_on`=1, `sel_n`=1 and `rd_en_n`=0 (verify), the next cycle drives the byte at `addr`.
- R8: With `hv_on`=1, `sel_n`=1 and `rd_en_n`=1 and no strobe before it (inhibit), nothing is written and `dout_oe`=0.
- R9: With `sig_on`=1, `sel_n`=0, `rd_en_n`=0 and `hv_on`=0, the next cycle drives 0x8F when `addr[0]`=0 and 0x04 when `addr[0]`=1, independent of the array.
- R10: While `erase_busy` is high, `dout_oe` is 0 in the following cycle, program strobes write nothing and a new `erase_req` does not restart the sweep.
- R11: With `hv_on`=1 and both `sel_n` and `rd_en_n` low, the block neither drives nor writes.
- R12: `dout` is 0 whenever `dout_oe` is 0; during reset `dout_oe`, `dout` and `erase_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; a low pulse is the program strobe |
| rd_en_n | input | 1 | Active-low read enable |
| hv_on | input | 1 | Programming supply raised |
| sig_on | input | 1 | Identification-code request |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte presented for programming |
| erase_req | input | 1 | Start a full-array erase |
| dout | output | 8 | Output byte |
| dout_oe | output | 1 | Drive enable for the tri-state pad |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The hardest case to reach is a program strobe that lands inside a running erase sweep, because the sweep rewrites every byte and can hide a stray write. The stimulus starts the sweep, then within its first few cycles fires a full strobe of 0x00 at address 0, which the sweep has already passed, and re-requests erase; a leaked write then shows up as 0x00 when address 0 is read after the sweep, and a restart shows up as a longer busy count. Strobes that end by dropping the supply, or that change data during the strobe, are driven so that the stored value tells which write, if any, happened.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MAKER_CODE  = 8'h8F;
    localparam logic [BYTE_W-1:0] DEVICE_CODE = 8'h04;

    typedef enum logic [3:0] {
        MD_READ     = 4'd0,
        MD_OFF      = 4'd1,
        MD_STANDBY  = 4'd2,
        MD_PROGRAM  = 4'd3,
        MD_VERIFY   = 4'd4,
        MD_INHIBIT  = 4'd5,
        MD_IDCODE   = 4'd6,
        MD_CLASH    = 4'd7,
        MD_ERASING  = 4'd8
    } mode_e;

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
    import uvprom_pkg::*;
(
    input  logic  sel_n,
    input  logic  rd_en_n,
    input  logic  hv_on,
    input  logic  sig_on,
    input  logic  sweeping,
    output mode_e mode
);

    always_comb begin
        if (sweeping) begin
            mode = MD_ERASING;
        end else if (hv_on) begin
            unique case ({sel_n, rd_en_n})
                2'b01:   mode = MD_PROGRAM;
                2'b10:   mode = MD_VERIFY;
                2'b11:   mode = MD_INHIBIT;
                default: mode = MD_CLASH;
            endcase
        end else if (sel_n) begin
            mode = MD_STANDBY;
        end else if (rd_en_n) begin
            mode = MD_OFF;
        end else if (sig_on) begin
            mode = MD_IDCODE;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Fill restores all ones; a normal write can only clear bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_fill) begin
                cells[wr_addr] <= '1;
            end else begin
                cells[wr_addr] <= cells[wr_addr] & wr_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/uvprom_core.sv
module uvprom_core
    import uvprom_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rd_en_n,
    input  logic              hv_on,
    input  logic              sig_on,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    input  logic              erase_req,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe,
    output logic              erase_busy
);

    localparam int                DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              drive;
        logic [BYTE_W-1:0] data;
        logic              strobe_live;
        logic [ADDR_W-1:0] strobe_addr;
        logic [BYTE_W-1:0] strobe_data;
        logic              sweeping;
        logic [ADDR_W-1:0] sweep_ptr;
    } core_state_t;

    core_state_t st_q, st_d;

    mode_e             mode;
    logic              arr_we;
    logic              arr_fill;
    logic [ADDR_W-1:0] arr_waddr;
    logic [BYTE_W-1:0] arr_wdata;
    logic [BYTE_W-1:0] arr_rdata;

    uvprom_mode_dec u_dec (
        .sel_n    (sel_n),
        .rd_en_n  (rd_en_n),
        .hv_on    (hv_on),
        .sig_on   (sig_on),
        .sweeping (st_q.sweeping),
        .mode     (mode)
    );

    uvprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_fill (arr_fill),
        .wr_addr (arr_waddr),
        .wr_data (arr_wdata),
        .rd_addr (addr),
        .rd_data (arr_rdata)
    );

    always_comb begin
        st_d             = st_q;
        st_d.strobe_live = 1'b0;
        arr_we           = 1'b0;
        arr_fill         = 1'b0;
        arr_waddr        = st_q.strobe_addr;
        arr_wdata        = st_q.strobe_data;

        // Write path: erase sweep, erase start, or strobe capture and commit.
        if (st_q.sweeping) begin
            arr_we    = 1'b1;
            arr_fill  = 1'b1;
            arr_waddr = st_q.sweep_ptr;
            if (st_q.sweep_ptr == LAST_ROW) begin
                st_d.sweeping = 1'b0;
            end else begin
                st_d.sweep_ptr = st_q.sweep_ptr + 1'b1;
            end
        end else if (erase_req) begin
            st_d.sweeping  = 1'b1;
            st_d.sweep_ptr = '0;
        end else begin
            unique case (mode)
                MD_PROGRAM: begin
                    st_d.strobe_live = 1'b1;
                    st_d.strobe_addr = addr;
                    st_d.strobe_data = din;
                end
                MD_INHIBIT: begin
                    // Strobe ends cleanly: commit the last captured byte once.
                    arr_we = st_q.strobe_live;
                end
                default: ;
            endcase
        end

        // Output path.
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                st_d.drive = 1'b1;
                st_d.data  = arr_rdata;
            end
            MD_IDCODE: begin
                st_d.drive = 1'b1;
                st_d.data  = addr[0] ? DEVICE_CODE : MAKER_CODE;
            end
            default: begin
                st_d.drive = 1'b0;
                st_d.data  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.data;
    assign dout_oe    = st_q.drive;
    assign erase_busy = st_q.sweeping;

endmodule

// File: rtl/uvprom_sva.sv
module uvprom_sva #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              rd_en_n,
    input logic              hv_on,
    input logic              sig_on,
    input logic [7:0]        dout,
    input logic              dout_oe,
    input logic              erase_busy
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 2;

    logic [CNT_W-1:0] busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (erase_busy) begin
            busy_len_q <= busy_len_q + 1'b1;
        end else begin
            busy_len_q <= '0;
        end
    end

    // R1: a sweep lasts exactly DEPTH cycles.
    a_r1_sweep_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_busy) |-> (busy_len_q == CNT_W'(DEPTH)));

    // R3: a plain read drives the bus next cycle.
    a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !rd_en_n && !hv_on && !sig_on && !erase_busy) |=> dout_oe);

    // R4: standby never drives.
    a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_on && sel_n) |=> !dout_oe);

    // R5: read enable high never drives.
    a_r5_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |=> !dout_oe);

    // R10: no drive during a sweep.
    a_r10_sweep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> !dout_oe);

    // R11: supply raised with both lows does not drive.
    a_r11_clash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_on && !sel_n && !rd_en_n) |=> !dout_oe);

    // R12: value is zero when not driving.
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == 8'h00));

endmodule

bind uvprom_core uvprom_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .rd_en_n    (rd_en_n),
    .hv_on      (hv_on),
    .sig_on     (sig_on),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .erase_busy (erase_busy)
);

// File: tb/uvprom_core_tb.sv
module uvprom_core_tb;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic              hv_on = 1'b0;
    logic              sig_on = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic              erase_req = 1'b0;
    logic [7:0]        dout;
    logic              dout_oe;
    logic              erase_busy;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit         oe;
        logic [7:0] dat;
        string      tag;
    } expect_t;

    expect_t    sb_q[$];
    logic [7:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    uvprom_core #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .rd_en_n    (rd_en_n),
        .hv_on      (hv_on),
        .sig_on     (sig_on),
        .addr       (addr),
        .din        (din),
        .erase_req  (erase_req),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .erase_busy (erase_busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and queue the expected output.
    task automatic drive(input bit s_n, input bit r_n, input bit hv, input bit sg,
                         input int a, input logic [7:0] d, input bit er,
                         input bit e_oe, input logic [7:0] e_dat, input string tag);
        expect_t it;
        @(negedge clk);
        sel_n = s_n; rd_en_n = r_n; hv_on = hv; sig_on = sg;
        addr = ADDR_W'(a); din = d; erase_req = er;
        it.oe = e_oe; it.dat = e_dat; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare one queued item per clock.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                expect_t it;
                it = sb_q.pop_front();
                check(dout_oe == it.oe, it.tag, "dout_oe", int'(dout_oe), int'(it.oe));
                check(dout == it.dat, it.tag, "dout", int'(dout), int'(it.dat));
            end
        end
    end

    task automatic read_byte(input int a, input string tag);
        drive(0, 0, 0, 0, a, 8'h00, 0, 1, ref_mem[a], tag);
    endtask

    task automatic strobe(input int a, input logic [7:0] d, input int len, input string tag);
        for (int i = 0; i < len; i++) drive(0, 1, 1, 0, a, d, 0, 0, 8'h00, tag);
        drive(1, 1, 1, 0, a, d, 0, 0, 8'h00, tag);
        ref_mem[a] = ref_mem[a] & d;
    endtask

    task automatic full_erase(input bit poke, input string tag);
        int len;
        drive(1, 1, 0, 0, 0, 8'h00, 1, 0, 8'h00, tag);
        len = 0;
        for (int i = 0; i < 2 * DEPTH; i++) begin
            if (poke && i < 3) begin
                drive(0, 0, 0, 0, 0, 8'h00, 0, 0, 8'h00, "R10");
            end else if (poke && (i == 3 || i == 4)) begin
                drive(0, 1, 1, 0, 0, 8'h00, i == 4, 0, 8'h00, "R10");
            end else if (poke && i == 5) begin
                drive(1, 1, 1, 0, 0, 8'h00, 0, 0, 8'h00, "R10");
            end else begin
                drive(1, 1, 0, 0, 0, 8'h00, 0, 0, 8'h00, tag);
            end
            if (erase_busy) len++;
            else break;
        end
        check(len == DEPTH, "R1", "busy cycles", len, DEPTH);
        for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dout_oe == 1'b0, "R12", "reset dout_oe", int'(dout_oe), 0);
        check(dout == 8'h00, "R12", "reset dout", int'(dout), 0);
        check(erase_busy == 1'b0, "R12", "reset busy", int'(erase_busy), 0);
        rst_n = 1'b1;

        // R1 and R10: erase with a strobe and a second request inside the sweep.
        full_erase(1'b1, "R1");
        read_byte(0, "R10");
        read_byte(5, "R1");
        read_byte(DEPTH - 1, "R1");

        // R6, R7: program and verify.
        strobe(5, 8'hA5, 2, "R6");
        drive(1, 0, 1, 0, 5, 8'h00, 0, 1, 8'hA5, "R7");
        // R2: second write only clears bits.
        strobe(5, 8'hF0, 1, "R2");
        drive(1, 0, 1, 0, 5, 8'h00, 0, 1, 8'hA0, "R2");

        // R6: long strobe, data changes late; one write of the last value.
        for (int i = 0; i < 3; i++) drive(0, 1, 1, 0, 7, 8'hFE, 0, 0, 8'h00, "R6");
        strobe(7, 8'hEF, 1, "R6");
        read_byte(7, "R6");

        // R6: strobe aborted by supply drop writes nothing.
        drive(0, 1, 1, 0, 9, 8'h00, 0, 0, 8'h00, "R6");
        drive(0, 1, 0, 0, 9, 8'h00, 0, 0, 8'h00, "R5");
        drive(1, 1, 1, 0, 9, 8'h00, 0, 0, 8'h00, "R8");
        read_byte(9, "R6");

        // R8: inhibit alone writes nothing.
        for (int i = 0; i < 3; i++) drive(1, 1, 1, 0, 10, 8'h00, 0, 0, 8'h00, "R8");
        read_byte(10, "R8");

        // R11: supply raised with both lows.
        drive(0, 0, 1, 0, 11, 8'h00, 0, 0, 8'h00, "R11");
        drive(1, 1, 1, 0, 11, 8'h00, 0, 0, 8'h00, "R11");
        read_byte(11, "R11");

        // R4, R5: standby and output disable.
        drive(1, 0, 0, 0, 5, 8'h00, 0, 0, 8'h00, "R4");
        drive(1, 1, 0, 0, 5, 8'h00, 0, 0, 8'h00, "R4");
        drive(0, 1, 0, 0, 5, 8'h00, 0, 0, 8'h00, "R5");

        // R9: identification codes.
        drive(0, 0, 0, 1, 0, 8'h00, 0, 1, 8'h8F, "R9");
        drive(0, 0, 0, 1, 1, 8'h00, 0, 1, 8'h04, "R9");
        drive(0, 0, 0, 1, 5, 8'h00, 0, 1, 8'h04, "R9");
        drive(0, 1, 0, 1, 0, 8'h00, 0, 0, 8'h00, "R9");

        // R3: plain reads of programmed and blank bytes.
        read_byte(5, "R3");
        read_byte(7, "R3");
        read_byte(12, "R3");

        // R1: erase restores programmed bytes.
        full_erase(1'b0, "R1");
        read_byte(5, "R1");
        read_byte(7, "R1");

        drive(1, 1, 0, 0, 0, 8'h00, 0, 0, 8'h00, "R4");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule